// File: doc/BRIEF.md
# USB Host Clock Gate

This block takes the second PLL's output and turns it into the 48 MHz clock for a USB host port. It switches the clock on and off under software control, and it lets the clock run only while that PLL reports lock. A configuration bit tells the block whether the PLL runs at 48 MHz or at 96 MHz. In the 96 MHz case the output comes from a divide-by-two toggle stage. In the 48 MHz case the PLL clock passes straight through a glitch-free gate.

Software works the gate through a small register port. Writing one to the host bit of the turn-on register requests the clock. Writing one to the host bit of the turn-off register withdraws the request. Writes of zero to either register do nothing. A status register shows whether the clock is running, whether a request is present, and the synchronized lock level. A request made while the PLL is unlocked stays pending and takes effect once lock is seen. When lock drops, the clock stops, but the request is kept. The host port also needs the master clock, which this block does not provide. The register port is clocked by the PLL clock, and the lock input is asynchronous.

Top module: `usb_host_clk_gate`

## Requirements
- R1: After reset the request, the running flag and the divide select are all 0, the status register reads 0, and `usb_clk` shows no rising edge.
- R2: A write with bit 0 set to address 0 (turn-on) sets the request (status bit 1) on the next edge. If the synchronized lock (status bit 2) is high, the running flag (status bit 0 and `clk_active`) rises one cycle later.
- R3: A write with bit 0 set to address 1 (turn-off) clears the request on the next edge and the running flag one cycle later. After that, `usb_clk` stays low.
- R4: A write to address 0 or 1 with bit 0 clear has no effect on the request or on the running state.
- R5: A request made while lock is low is held pending (status bit 1 = 1, bit 0 = 0) and `usb_clk` stays idle. After `lock_in` rises, the clock starts within three cycles.
- R6: The lock input passes through a two-flop synchronizer. When lock has been low for more than two cycles, the clock is gated off and the request is kept. When lock returns, the clock restarts.
- R7: With divide select 0 (address 3, bit 0), `usb_clk` gives one rising edge per PLL clock. With divide select 1, it gives one rising edge per two PLL clocks.
- R8: A change of the divide select takes effect only while the clock is gated off. A running clock keeps its current ratio.
- R9: Address 3 reads back the divide select in bit 0, and address 2 reads status as {lock, request, running} in bits 2..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL output clock; also clocks the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_in | input | 1 | Asynchronous PLL lock indication |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 turn-on, 1 turn-off, 3 config |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address: 2 status, 3 config, others read 0 |
| rd_data | output | DATA_W | Combinational read data |
| usb_clk | output | 1 | Gated, optionally halved, USB clock |
| clk_active | output | 1 | High while the gated clock runs |

## Verification
The bench counts `usb_clk` rising edges over fixed windows. A divider path that is wired backwards gives 40 edges where 20 are expected, or the reverse. A gate that ignores lock gives edges while the request is still pending. If the divide select is applied while the clock runs, the edge count changes in the middle of a run. A turn-off register that reacts to zero data loses the request on a harmless write. If lock loss also clears the request, the clock stays dead after the PLL relocks. A randomized stretch compares the status bits on every cycle against a cycle model of the synchronizer and the request.

// File: rtl/usbg_pkg.sv
package usbg_pkg;
  typedef enum logic [1:0] {
    REG_ON   = 2'd0,
    REG_OFF  = 2'd1,
    REG_STAT = 2'd2,
    REG_CFG  = 2'd3
  } usbg_reg_e;
endpackage

// File: rtl/usbg_lock_sync.sv
module usbg_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/usbg_ctrl.sv
module usbg_ctrl
  import usbg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HOST_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lock_s,
  output logic              req_q,
  output logic              act_q,
  output logic              div_sel_q,
  output logic              div_cur_q
);
  logic set_hit, clr_hit, cfg_hit;

  assign set_hit = wr_en && (usbg_reg_e'(wr_addr) == REG_ON)  && wr_data[HOST_BIT];
  assign clr_hit = wr_en && (usbg_reg_e'(wr_addr) == REG_OFF) && wr_data[HOST_BIT];
  assign cfg_hit = wr_en && (usbg_reg_e'(wr_addr) == REG_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      act_q     <= 1'b0;
      div_sel_q <= 1'b0;
      div_cur_q <= 1'b0;
    end else begin
      if (set_hit)      req_q <= 1'b1;
      else if (clr_hit) req_q <= 1'b0;
      act_q <= req_q && lock_s;
      if (cfg_hit) div_sel_q <= wr_data[0];
      if (!act_q)  div_cur_q <= div_sel_q;
    end
  end
endmodule

// File: rtl/usbg_clk_out.sv
module usbg_clk_out (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic div2,
  output logic usb_clk,
  output logic tog_q
);
  logic pass_en_n;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pass_en_n <= 1'b0;
    else        pass_en_n <= act && !div2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tog_q <= 1'b0;
    else if (act && div2) tog_q <= !tog_q;
    else                  tog_q <= 1'b0;
  end

  assign usb_clk = (clk && pass_en_n) || tog_q;
endmodule

// File: rtl/usb_host_clk_gate.sv
module usb_host_clk_gate
  import usbg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HOST_BIT    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_in,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              usb_clk,
  output logic              clk_active
);
  logic lock_s, req_w, act_w, div_sel_w, div_cur_w, tog_w;

  usbg_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(lock_in), .sync_out(lock_s)
  );

  usbg_ctrl #(.DATA_W(DATA_W), .HOST_BIT(HOST_BIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lock_s(lock_s), .req_q(req_w), .act_q(act_w),
    .div_sel_q(div_sel_w), .div_cur_q(div_cur_w)
  );

  usbg_clk_out u_out (
    .clk(clk), .rst_n(rst_n), .act(act_w), .div2(div_cur_w),
    .usb_clk(usb_clk), .tog_q(tog_w)
  );

  always_comb begin
    rd_data = '0;
    case (usbg_reg_e'(rd_addr))
      REG_STAT: rd_data[2:0] = {lock_s, req_w, act_w};
      REG_CFG:  rd_data[0]   = div_sel_w;
      default:  rd_data      = '0;
    endcase
  end

  assign clk_active = act_w;
endmodule

// File: rtl/usbg_checker.sv
module usbg_checker #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lock_in,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              req,
  input logic              act,
  input logic              div_cur,
  input logic              tog
);
  localparam int CW = $clog2(SYNC_STAGES + 2) + 1;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (lock_in) low_cnt <= '0;
    else if (low_cnt <= CW'(SYNC_STAGES)) low_cnt <= low_cnt + 1'b1;
  end

  AST_LOCK_LOSS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (low_cnt > CW'(SYNC_STAGES)) |-> !act); // R6
  AST_OFF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && wr_data[0]) |=> ##1 !act); // R3
  AST_ZERO_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[1] == 1'b0 && !wr_data[0]) |=> $stable(req)); // R4
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act)) |-> $stable(div_cur)); // R8
  AST_IDLE_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !tog); // R7
endmodule

bind usb_host_clk_gate usbg_checker #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .req(req_w), .act(act_w), .div_cur(div_cur_w), .tog(tog_w)
);

// File: tb/usb_host_clk_gate_tb.sv
module usb_host_clk_gate_tb;
  localparam int DW = 8;
  logic clk = 1'b0, rst_n = 1'b0, lock_in = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = 2'd2;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic usb_clk, clk_active;
  int checks = 0, fails = 0, edges = 0;
  logic m_req = 0, m_act = 0, m_ls1 = 0, m_ls2 = 0, m_sel = 0;

  always #4 clk = ~clk;

  usb_host_clk_gate u_dut (
    .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .usb_clk(usb_clk),
    .clk_active(clk_active)
  );

  always @(posedge usb_clk) edges++;

  function automatic logic [2:0] exp_stat();
    return {m_ls2, m_req, m_act};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    m_act = m_req & m_ls2;
    m_ls2 = m_ls1;
    m_ls1 = lock_in;
    if (wr_en && wr_addr == 2'd0 && wr_data[0]) m_req = 1'b1;
    else if (wr_en && wr_addr == 2'd1 && wr_data[0]) m_req = 1'b0;
    if (wr_en && wr_addr == 2'd3) m_sel = wr_data[0];
    @(negedge clk); #1;
  endtask

  task automatic chk_stat(input string tag);
    rd_addr = 2'd2; #1;
    chk(rd_data[2:0] == exp_stat() && clk_active == m_act, tag,
        int'(rd_data[2:0]), int'(exp_stat()));
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic count_edges(input int n, input int exp, input string tag);
    edges = 0;
    for (int i = 0; i < n; i++) cyc();
    chk(edges == exp, tag, edges, exp);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    process::self().srandom(32'h1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_stat("R1 reset status");
    rd_addr = 2'd3; #1;
    chk(rd_data == 0, "R1 reset cfg", int'(rd_data), 0);
    count_edges(10, 0, "R1 no edges after reset");

    wr(2'd0, 8'h01);
    cyc(); cyc();
    chk_stat("R5 pending while unlocked");
    count_edges(10, 0, "R5 idle while pending");
    lock_in = 1'b1;
    cyc(); cyc(); cyc();
    chk_stat("R5 start after lock");
    chk(clk_active == 1'b1, "R2 running after lock", int'(clk_active), 1);
    count_edges(40, 40, "R7 divide by one");

    wr(2'd3, 8'h01);
    rd_addr = 2'd3; #1;
    chk(rd_data[0] == 1'b1, "R9 cfg readback", int'(rd_data[0]), 1);
    count_edges(40, 40, "R8 ratio held while running");

    wr(2'd0, 8'h00); wr(2'd1, 8'hFE);
    chk_stat("R4 zero writes ignored");
    count_edges(20, 20, "R4 clock unchanged");

    wr(2'd1, 8'h01);
    cyc();
    chk_stat("R3 off clears running");
    count_edges(20, 0, "R3 clock stopped");

    wr(2'd0, 8'h01);
    cyc(); cyc();
    chk_stat("R2 on with lock");
    count_edges(40, 20, "R7 divide by two");

    lock_in = 1'b0;
    cyc(); cyc(); cyc();
    chk_stat("R6 lock loss gates");
    chk(clk_active == 1'b0, "R6 inactive", int'(clk_active), 0);
    count_edges(10, 0, "R6 no edges unlocked");
    lock_in = 1'b1;
    cyc(); cyc(); cyc();
    chk_stat("R6 relock restarts");

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) lock_in = ~lock_in;
      wr_en = (r >= 6);
      wr_addr = 2'($urandom_range(0, 1));
      wr_data = DW'($urandom_range(0, 3));
      cyc();
      wr_en = 1'b0;
      chk_stat("R2 R3 R4 R6 random status");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule